// File: doc/BRIEF.md
# Cartridge Bank Mapper with Clock-Register Select

This block sits on the write side of a cartridge's 8-bit data bus and 16-bit address bus. It decodes CPU writes into the lower half of the address space (address bit 15 clear) and turns them into mapping state. That state is an enable for the external window, a switchable ROM bank number, and a shared selector. The selector points the external window either at a RAM bank or at one of five real-time-clock registers.

Writes in the top quarter of the lower half drive a two-step handshake. A write of zero followed by a write of one freezes the clock registers. The block marks that moment with a one-cycle strobe, and the counting logic outside the block takes its snapshot on that strobe. All outputs are registered and follow the write by one clock.

Top module: `bank_mapper`

## Requirements
- R1: After a synchronous active-high reset, `win_en` is 0, `rom_bank` is 1, `ram_bank` is 0, `clk_sel_en` is 0, `clk_reg` is 0, `snap_held` is 0 and `snap_pulse` is 0.
- R2: A write with `wr_addr[15]` set changes no output. The region is `wr_addr[14:13]`.
- R3: In region 0, data 0x0A sets `win_en` and data 0x00 clears it. Any other data leaves `win_en` unchanged.
- R4: In region 1, `rom_bank` takes `wr_data[6:0]`, except that a result of 0 is stored as 1. `rom_bank` is therefore never 0.
- R5: In region 2, data 0 to 3 loads `ram_bank` with that value and clears `clk_sel_en`.
- R6: In region 2, data 0x08 to 0x0C loads `clk_reg` with data minus 8 and sets `clk_sel_en`. `ram_bank` is unchanged.
- R7: In region 2, data 4 to 7 and data above 0x0C change no output.
- R8: In region 3, data 1 while `snap_held` is 0 sets `snap_held` and produces `snap_pulse` high for exactly one cycle.
- R9: In region 3, data 0 while `snap_held` is 1 clears `snap_held`. Every other region-3 write changes nothing and gives no pulse.
- R10: Every output changes on the clock edge that samples the write (`wr_en` high), and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data |
| win_en | output | 1 | External RAM/clock window enabled |
| rom_bank | output | 7 | Switchable ROM bank number |
| ram_bank | output | 2 | RAM bank number |
| clk_sel_en | output | 1 | Window maps a clock register instead of RAM |
| clk_reg | output | 3 | Selected clock register index, 0 to 4 |
| snap_held | output | 1 | Clock snapshot held |
| snap_pulse | output | 1 | One-cycle strobe to take a clock snapshot |

## Verification
Some properties are checked every cycle. `rom_bank` is never zero and `clk_reg` never exceeds 4. Every output stays stable in cycles without a write or with address bit 15 set. A strobe always comes with the held flag rising, and only after a region-3 write of 1.

Other behaviour needs the bench's sequences. These include the exact values loaded, the return to a RAM bank after clock selection, and the gaps in the selector range. The bench also covers the ignored enable codes and the need for a release (a zero) before a second strobe.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 8;
  localparam int ROM_W   = 7;
  localparam int RAM_W   = 2;
  localparam int CREG_W  = 3;

  typedef enum logic [1:0] {
    RGN_ENABLE = 2'd0,
    RGN_ROM    = 2'd1,
    RGN_SELECT = 2'd2,
    RGN_SNAP   = 2'd3
  } region_e;

  localparam logic [DATA_W-1:0] EN_ON_CODE  = 8'h0A;
  localparam logic [DATA_W-1:0] EN_OFF_CODE = 8'h00;
  localparam logic [DATA_W-1:0] CREG_FIRST  = 8'h08;
  localparam logic [DATA_W-1:0] CREG_LAST   = 8'h0C;
endpackage

// File: rtl/bank_mapper_decode.sv
module bank_mapper_decode
  import bank_mapper_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  output logic [3:0]    rgn_hit
);
  logic    in_space;
  region_e rgn;

  always_comb begin
    in_space = wr_en && !wr_addr[AW-1];
    rgn      = region_e'(wr_addr[AW-2:AW-3]);
  end

  for (genvar g = 0; g < 4; g++) begin : g_hit
    assign rgn_hit[g] = in_space && (rgn == region_e'(g));
  end
endmodule

// File: rtl/bank_mapper_select.sv
module bank_mapper_select
  import bank_mapper_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int RW = RAM_W,
  parameter int CW = CREG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit,
  input  logic [DW-1:0] data,
  output logic [RW-1:0] ram_bank,
  output logic          clk_sel_en,
  output logic [CW-1:0] clk_reg
);
  localparam int RAM_BANKS = 1 << RW;

  logic            is_ram, is_creg;
  logic [DW-1:0]   creg_off;

  always_comb begin
    is_ram   = data < DW'(RAM_BANKS);
    is_creg  = (data >= CREG_FIRST) && (data <= CREG_LAST);
    creg_off = data - CREG_FIRST;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_bank   <= '0;
      clk_sel_en <= 1'b0;
      clk_reg    <= '0;
    end else if (hit) begin
      if (is_ram) begin
        ram_bank   <= data[RW-1:0];
        clk_sel_en <= 1'b0;
      end else if (is_creg) begin
        clk_reg    <= creg_off[CW-1:0];
        clk_sel_en <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bank_mapper_snap.sv
module bank_mapper_snap
  import bank_mapper_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit,
  input  logic [DW-1:0] data,
  output logic          snap_held,
  output logic          snap_pulse
);
  logic take, release_w;

  always_comb begin
    take      = hit && !snap_held && (data == DW'(1));
    release_w = hit &&  snap_held && (data == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_held  <= 1'b0;
      snap_pulse <= 1'b0;
    end else begin
      snap_pulse <= take;
      if (take)           snap_held <= 1'b1;
      else if (release_w) snap_held <= 1'b0;
    end
  end
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import bank_mapper_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int BW = ROM_W,
  parameter int RW = RAM_W,
  parameter int CW = CREG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          win_en,
  output logic [BW-1:0] rom_bank,
  output logic [RW-1:0] ram_bank,
  output logic          clk_sel_en,
  output logic [CW-1:0] clk_reg,
  output logic          snap_held,
  output logic          snap_pulse
);
  logic [3:0] rgn_hit;

  bank_mapper_decode #(.AW(AW)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .rgn_hit(rgn_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      win_en <= 1'b0;
    end else if (rgn_hit[RGN_ENABLE]) begin
      if (wr_data == EN_ON_CODE)       win_en <= 1'b1;
      else if (wr_data == EN_OFF_CODE) win_en <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_bank <= BW'(1);
    end else if (rgn_hit[RGN_ROM]) begin
      if (wr_data[BW-1:0] == '0) rom_bank <= BW'(1);
      else                       rom_bank <= wr_data[BW-1:0];
    end
  end

  bank_mapper_select #(.DW(DW), .RW(RW), .CW(CW)) u_sel (
    .clk(clk), .rst(rst), .hit(rgn_hit[RGN_SELECT]), .data(wr_data),
    .ram_bank(ram_bank), .clk_sel_en(clk_sel_en), .clk_reg(clk_reg)
  );

  bank_mapper_snap #(.DW(DW)) u_snap (
    .clk(clk), .rst(rst), .hit(rgn_hit[RGN_SNAP]), .data(wr_data),
    .snap_held(snap_held), .snap_pulse(snap_pulse)
  );
endmodule

// File: rtl/bank_mapper_chk.sv
module bank_mapper_chk #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int BW = 7,
  parameter int RW = 2,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          win_en,
  input logic [BW-1:0] rom_bank,
  input logic [RW-1:0] ram_bank,
  input logic          clk_sel_en,
  input logic [CW-1:0] clk_reg,
  input logic          snap_held,
  input logic          snap_pulse
);
  logic idle;
  assign idle = !wr_en || wr_addr[AW-1];

  assert_rom_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
    rom_bank != '0);

  assert_creg_range_R6: assert property (@(posedge clk) disable iff (rst)
    clk_reg <= CW'(4));

  assert_idle_stable_R2: assert property (@(posedge clk) disable iff (rst)
    idle |=> ($stable(win_en) && $stable(rom_bank) && $stable(ram_bank) &&
              $stable(clk_sel_en) && $stable(clk_reg) && $stable(snap_held)));

  assert_idle_no_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    idle |=> !snap_pulse);

  assert_pulse_with_hold_R8: assert property (@(posedge clk) disable iff (rst)
    snap_pulse |-> $rose(snap_held));

  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (rst)
    snap_pulse |=> !snap_pulse);

  assert_take_pulses_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr[AW-1:AW-3] == 3'b011 && wr_data == DW'(1) && !snap_held)
      |=> snap_pulse);

  assert_release_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr[AW-1:AW-3] == 3'b011 && wr_data == '0 && snap_held)
      |=> (!snap_held && !snap_pulse));
endmodule

bind bank_mapper bank_mapper_chk #(.AW(AW), .DW(DW), .BW(BW), .RW(RW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .win_en(win_en), .rom_bank(rom_bank), .ram_bank(ram_bank),
  .clk_sel_en(clk_sel_en), .clk_reg(clk_reg), .snap_held(snap_held),
  .snap_pulse(snap_pulse)
);

// File: tb/bank_mapper_tb.sv
module bank_mapper_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;
  logic        win_en, clk_sel_en, snap_held, snap_pulse;
  logic [6:0]  rom_bank;
  logic [1:0]  ram_bank;
  logic [2:0]  clk_reg;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // reference model state
  logic       m_en, m_csel, m_held, m_pulse;
  logic [6:0] m_rom;
  logic [1:0] m_ram;
  logic [2:0] m_creg;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_mapper u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .win_en(win_en), .rom_bank(rom_bank), .ram_bank(ram_bank),
    .clk_sel_en(clk_sel_en), .clk_reg(clk_reg), .snap_held(snap_held),
    .snap_pulse(snap_pulse)
  );

  function automatic logic [6:0] exp_rom(input logic [7:0] d);
    return (d[6:0] == 7'd0) ? 7'd1 : d[6:0];
  endfunction

  task automatic model_reset();
    m_en = 0; m_csel = 0; m_held = 0; m_pulse = 0;
    m_rom = 7'd1; m_ram = 0; m_creg = 0;
  endtask

  task automatic model_write(input logic [15:0] a, input logic [7:0] d);
    m_pulse = 0;
    if (!a[15]) begin
      case (a[14:13])
        2'd0: if (d == 8'h0A) m_en = 1; else if (d == 8'h00) m_en = 0;
        2'd1: m_rom = exp_rom(d);
        2'd2: if (d < 8'd4) begin m_ram = d[1:0]; m_csel = 0; end
              else if (d >= 8'h08 && d <= 8'h0C) begin m_creg = 3'(d - 8'h08); m_csel = 1; end
        default: if (d == 8'd1 && !m_held) begin m_held = 1; m_pulse = 1; end
                 else if (d == 8'd0 && m_held) m_held = 0;
      endcase
    end
  endtask

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check(req, "win_en", 32'(win_en), 32'(m_en));
    check(req, "rom_bank", 32'(rom_bank), 32'(m_rom));
    check(req, "ram_bank", 32'(ram_bank), 32'(m_ram));
    check(req, "clk_sel_en", 32'(clk_sel_en), 32'(m_csel));
    check(req, "clk_reg", 32'(clk_reg), 32'(m_creg));
    check(req, "snap_held", 32'(snap_held), 32'(m_held));
    check(req, "snap_pulse", 32'(snap_pulse), 32'(m_pulse));
  endtask

  // drive write at negedge, result visible after next posedge; sample at following negedge
  task automatic wr(input logic [15:0] a, input logic [7:0] d, input string req);
    wr_en = 1; wr_addr = a; wr_data = d;
    model_write(a, d);
    @(negedge clk);
    wr_en = 0;
    check_all(req);
  endtask

  task automatic idle_cycle(input string req);
    m_pulse = 0;
    @(negedge clk);
    check_all(req);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1; wr_en = 0; wr_addr = 0; wr_data = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    check_all("R1");

    // R3 enable codes
    wr(16'h0000, 8'h0A, "R3");
    wr(16'h1FFF, 8'h55, "R3");
    wr(16'h0100, 8'h00, "R3");
    wr(16'h0100, 8'h0B, "R3");
    wr(16'h0000, 8'h0A, "R3");
    // R2 bit 15 ignored (would disable, set rom bank, select clock)
    wr(16'h8000, 8'h00, "R2");
    wr(16'hA000, 8'h05, "R2");
    wr(16'hC000, 8'h09, "R2");
    // R4 rom bank
    wr(16'h2000, 8'h00, "R4");
    wr(16'h3FFF, 8'h80, "R4");
    wr(16'h2000, 8'hFF, "R4");
    wr(16'h2000, 8'h15, "R4");
    // R5/R6/R7 selector
    wr(16'h4000, 8'h03, "R5");
    wr(16'h4000, 8'h0C, "R6");
    check("R6", "ram_bank kept", 32'(ram_bank), 32'd3);
    wr(16'h5000, 8'h04, "R7");
    wr(16'h4000, 8'h07, "R7");
    wr(16'h4000, 8'h0D, "R7");
    wr(16'h4000, 8'hFF, "R7");
    wr(16'h4000, 8'h08, "R6");
    wr(16'h4000, 8'h01, "R5");
    // R8/R9 handshake
    wr(16'h6000, 8'h01, "R8");
    check("R8", "pulse", 32'(snap_pulse), 32'd1);
    idle_cycle("R10");
    check("R8", "pulse one cycle", 32'(snap_pulse), 32'd0);
    wr(16'h6000, 8'h01, "R9");
    check("R9", "no repeat pulse", 32'(snap_pulse), 32'd0);
    wr(16'h6000, 8'h02, "R9");
    wr(16'h7FFF, 8'h00, "R9");
    check("R9", "released", 32'(snap_held), 32'd0);
    wr(16'h6000, 8'h00, "R9");
    wr(16'h6000, 8'h01, "R8");
    // R10 idle cycles change nothing
    repeat (3) idle_cycle("R10");

    // random mix
    for (int i = 0; i < 2000; i++) begin
      logic [15:0] a;
      logic [7:0]  d;
      a = 16'($urandom);
      d = ($urandom_range(0, 1) == 0) ? 8'($urandom_range(0, 15)) : 8'($urandom);
      if ($urandom_range(0, 4) == 0) idle_cycle("R10");
      else wr(a, d, "R2");
    end

    // reset again mid-state
    rst = 1; model_reset();
    @(negedge clk);
    rst = 0;
    check_all("R1");

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule